// File: doc/BRIEF.md
# Channel Interrupt Holdoff and Rearm Controller

This block sits between a DMA channel's completion-event pulse and its interrupt line. A completion event starts a holdoff timer that counts whole microseconds. The interrupt line rises only when the holdoff expires. Further events that arrive while the timer runs, or while the line is high, produce no extra interrupt. They are remembered as one pending event. This merges a burst of completions into a single interrupt.

Each delivered interrupt masks the channel. The line stays high until software writes the arm bit in the channel control register. If an event is pending at that write, a fresh holdoff starts at once. The microsecond tick comes from a prescaler that divides the clock by `CLKS_PER_US`. Two registers are visible. The first is a 16-bit delay register at byte offset 0x0C: its bits 13:0 hold the holdoff in microseconds, and bit 15 reads as a constant 1 to show that merging is supported. The second is a channel control register at byte offset 0x10, whose bit 0 is the arm bit.

Top module: `intr_holdoff_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the delay register (offset 0x0C) reads 0x8000, and control bit 0 (offset 0x10) reads 1 (armed).
- R2: When an event is sampled on an armed, idle channel with a delay D of 1 or more, the interrupt output rises exactly D*CLKS_PER_US clock cycles after that sampling edge.
- R3: When the delay is 0, an event on an armed, idle channel raises the interrupt output on the next clock edge.
- R4: Once the interrupt output is high, it stays high until a write to offset 0x10 with bit 0 set. If no event is pending at that write, the output falls on that edge.
- R5: Events that arrive during a holdoff, or while the interrupt output is high, are held as one pending event. A rearm write then starts a new holdoff, and the output rises D*CLKS_PER_US cycles after the rearm edge. With D of 0, the output simply stays high.
- R6: Extra events during a holdoff do not move the expiry. The interrupt timing is set by the event that started the holdoff.
- R7: A write to offset 0x0C stores bits 13:0 only. A read returns bit 15 as 1, bit 14 as 0, and bits 13:0 as stored.
- R8: A write to the delay register during a running holdoff does not change that holdoff. The new value applies to the next holdoff.
- R9: A write to offset 0x10 with bit 0 set on an idle channel has no effect. A write to offset 0x10 with bit 0 clear never lowers the interrupt output.
- R10: An event sampled on the same edge as a rearm write is treated as pending, so a new holdoff starts at that edge.
- R11: Control bit 0 reads 1 whenever the interrupt output is low, and 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 1 | Completion event, one cycle per event |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational from regAddr |
| intrOut | output | 1 | Level interrupt to the channel's host |

## Verification
The sharpest collision is a rearm write and a new completion event landing on the same edge. It can also happen that the rearm finds a pending event while the delay is zero. The bench provokes the first directly: it raises evtPulse in the same cycle as the arm write. It then expects the line to drop and rise again exactly one full holdoff later. Random trials inject events during holdoffs and after delivery. The bench then repeats rearm writes, predicting each rise time or drop from the programmed delay and its own record of whether an event is pending.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  localparam int DLY_W = 14;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_HOLD  = 2'd1,
    CH_FIRED = 2'd2
  } chanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic pendSet;
    logic pendClr;
    logic wrDelay;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic expire;
    logic delayZero;
    logic pending;
  } dpStatus_t;
endpackage

// File: rtl/ihc_ctrl.sv
module ihc_ctrl
  import ihc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DELAY_OFF = 'h0C,
  parameter int CTRL_OFF  = 'h10,
  parameter int ARM_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtPulse,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  dpStatus_t         status,
  output dpStrobe_t         strobe,
  output chanState_e        curState
);
  chanState_e nextState;
  logic rearm;

  assign rearm = regWrEn && (regAddr == ADDR_W'(CTRL_OFF)) && regWrData[ARM_BIT];

  always_comb begin
    nextState      = curState;
    strobe         = '0;
    strobe.wrDelay = regWrEn && (regAddr == ADDR_W'(DELAY_OFF));
    unique case (curState)
      CH_IDLE: begin
        if (evtPulse) begin
          if (status.delayZero) begin
            nextState = CH_FIRED;
          end else begin
            strobe.loadCnt = 1'b1;
            nextState      = CH_HOLD;
          end
        end
      end
      CH_HOLD: begin
        strobe.pendSet = evtPulse;
        if (status.expire) nextState = CH_FIRED;
      end
      CH_FIRED: begin
        strobe.pendSet = evtPulse;
        if (rearm) begin
          if (status.pending || evtPulse) begin
            strobe.pendClr = 1'b1;
            if (status.delayZero) begin
              nextState = CH_FIRED;
            end else begin
              strobe.loadCnt = 1'b1;
              nextState      = CH_HOLD;
            end
          end else begin
            nextState = CH_IDLE;
          end
        end
      end
      default: nextState = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= CH_IDLE;
    else       curState <= nextState;
  end
endmodule

// File: rtl/ihc_datapath.sv
module ihc_datapath
  import ihc_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int ADDR_W      = 8,
  parameter int DELAY_OFF   = 'h0C,
  parameter int CTRL_OFF    = 'h10,
  parameter int ARM_BIT     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              armed,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output dpStatus_t         status,
  output logic [DLY_W-1:0]  delayVal,
  output logic [REG_W-1:0]  regRdData
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0] preCnt;
  logic [DLY_W-1:0] holdCnt;
  logic             pendReg;
  logic             usTick;

  assign usTick = (preCnt == PRE_LAST);

  // delay register, low field only
  always_ff @(posedge clk) begin
    if (!rstN)               delayVal <= '0;
    else if (strobe.wrDelay) delayVal <= regWrData[DLY_W-1:0];
  end

  // prescaler and holdoff counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      holdCnt <= '0;
    end else if (strobe.loadCnt) begin
      preCnt  <= '0;
      holdCnt <= delayVal;
    end else if (holdCnt != '0) begin
      preCnt <= usTick ? '0 : preCnt + 1'b1;
      if (usTick) holdCnt <= holdCnt - 1'b1;
    end
  end

  // pending event latch, clear wins
  always_ff @(posedge clk) begin
    if (!rstN)               pendReg <= 1'b0;
    else if (strobe.pendClr) pendReg <= 1'b0;
    else if (strobe.pendSet) pendReg <= 1'b1;
  end

  assign status.expire    = usTick && (holdCnt == DLY_W'(1));
  assign status.delayZero = (delayVal == '0);
  assign status.pending   = pendReg;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(DELAY_OFF)) begin
      regRdData            = {1'b1, 1'b0, delayVal};
    end else if (regAddr == ADDR_W'(CTRL_OFF)) begin
      regRdData[ARM_BIT]   = armed;
    end
  end
endmodule

// File: rtl/intr_holdoff_ctrl.sv
module intr_holdoff_ctrl
  import ihc_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int ADDR_W      = 8,
  parameter int DELAY_OFF   = 'h0C,
  parameter int CTRL_OFF    = 'h10,
  parameter int ARM_BIT     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtPulse,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              intrOut
);
  dpStrobe_t        strobe;
  dpStatus_t        status;
  chanState_e       curState;
  logic [DLY_W-1:0] delayVal;
  logic             stIdle;

  ihc_ctrl #(
    .ADDR_W(ADDR_W), .DELAY_OFF(DELAY_OFF), .CTRL_OFF(CTRL_OFF), .ARM_BIT(ARM_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .status(status),
    .strobe(strobe), .curState(curState)
  );

  ihc_datapath #(
    .CLKS_PER_US(CLKS_PER_US), .ADDR_W(ADDR_W), .DELAY_OFF(DELAY_OFF),
    .CTRL_OFF(CTRL_OFF), .ARM_BIT(ARM_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .armed(!intrOut),
    .regAddr(regAddr), .regWrData(regWrData), .status(status),
    .delayVal(delayVal), .regRdData(regRdData)
  );

  assign intrOut = (curState == CH_FIRED);
  assign stIdle  = (curState == CH_IDLE);
endmodule

// File: rtl/intr_holdoff_ctrl_chk.sv
module intr_holdoff_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int DELAY_OFF = 'h0C,
  parameter int CTRL_OFF  = 'h10,
  parameter int ARM_BIT   = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtPulse,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [15:0]       regWrData,
  input logic [15:0]       regRdData,
  input logic              intrOut,
  input logic [13:0]       delayVal,
  input logic              stIdle
);
  logic rearmW;
  assign rearmW = regWrEn && (regAddr == ADDR_W'(CTRL_OFF)) && regWrData[ARM_BIT];

  // R4
  intr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intrOut && !rearmW) |=> intrOut);

  // R3
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stIdle && evtPulse && delayVal == '0) |=> intrOut);

  // R2
  no_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stIdle && evtPulse && delayVal != '0) |=> !intrOut);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stIdle && !evtPulse) |=> !intrOut);

  // R7
  delay_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(DELAY_OFF)) |-> (regRdData[15:14] == 2'b10));

  // R11
  arm_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(CTRL_OFF)) |-> (regRdData[ARM_BIT] == !intrOut));
endmodule

bind intr_holdoff_ctrl intr_holdoff_ctrl_chk #(
  .ADDR_W(ADDR_W), .DELAY_OFF(DELAY_OFF), .CTRL_OFF(CTRL_OFF), .ARM_BIT(ARM_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .intrOut(intrOut), .delayVal(delayVal), .stIdle(stIdle)
);

// File: tb/tb_intr_holdoff_ctrl.sv
module tb_intr_holdoff_ctrl;
  localparam int PERIOD = 10;
  localparam int K      = 4;
  localparam logic [7:0] DLY_A = 8'h0C;
  localparam logic [7:0] CTL_A = 8'h10;

  logic clk = 0;
  logic rstN = 0;
  logic evtPulse = 0;
  logic regWrEn = 0;
  logic [7:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic intrOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  intr_holdoff_ctrl #(.CLKS_PER_US(K)) dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .intrOut(intrOut)
  );

  function automatic int expRise(int d);
    return d * K;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, logic withEvt = 1'b0);
    regAddr = a; regWrData = d; regWrEn = 1'b1; evtPulse = withEvt;
    @(negedge clk);
    regWrEn = 1'b0; evtPulse = 1'b0; regAddr = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = '0;
  endtask

  task automatic pulse();
    evtPulse = 1'b1;
    @(negedge clk);
    evtPulse = 1'b0;
  endtask

  task automatic waitIntr(int startN, int injPct, output int n, output bit inj);
    n = startN; inj = 0;
    while (!intrOut && n < 400) begin
      evtPulse = (int'($urandom % 100) < injPct);
      if (evtPulse) inj = 1;
      @(negedge clk);
      n++;
    end
    evtPulse = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    int n;
    bit inj;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(intrOut == 0, "R1 intr", intrOut, 0);
    rd(DLY_A, rv); check(rv == 16'h8000, "R1 delay", rv, 16'h8000);
    rd(CTL_A, rv); check(rv[0] == 1, "R1 armed", rv[0], 1);

    // R7 masked writes
    wr(DLY_A, 16'hFFFF); rd(DLY_A, rv); check(rv == 16'hBFFF, "R7 all ones", rv, 16'hBFFF);
    wr(DLY_A, 16'h4005); rd(DLY_A, rv); check(rv == 16'h8005, "R7 bit14", rv, 16'h8005);

    // R3 zero delay
    wr(DLY_A, 16'h0000); pulse();
    check(intrOut == 1, "R3 zero delay", intrOut, 1);
    rd(CTL_A, rv); check(rv[0] == 0, "R11 masked", rv[0], 0);
    // R9 control write with bit0 clear
    wr(CTL_A, 16'h0000); check(intrOut == 1, "R9 bit0 clear", intrOut, 1);
    // R4 stays high
    repeat (20) @(negedge clk);
    check(intrOut == 1, "R4 held", intrOut, 1);
    wr(CTL_A, 16'h0001); check(intrOut == 0, "R4 rearm drop", intrOut, 0);
    rd(CTL_A, rv); check(rv[0] == 1, "R11 rearmed", rv[0], 1);

    // R9 rearm on idle channel
    wr(CTL_A, 16'h0001); check(intrOut == 0, "R9 idle rearm", intrOut, 0);

    // R2 delay 3
    wr(DLY_A, 16'd3); pulse(); waitIntr(0, 0, n, inj);
    check(n == expRise(3), "R2 delay3", n, expRise(3));
    wr(CTL_A, 16'h0001); check(intrOut == 0, "R4 clear", intrOut, 0);

    // R8 delay change mid holdoff
    wr(DLY_A, 16'd5); pulse(); wr(DLY_A, 16'd1); waitIntr(1, 0, n, inj);
    check(n == expRise(5), "R8 running", n, expRise(5));
    wr(CTL_A, 16'h0001);
    pulse(); waitIntr(0, 0, n, inj);
    check(n == expRise(1), "R8 next", n, expRise(1));

    // R10 event on rearm edge
    wr(DLY_A, 16'd2);
    wr(CTL_A, 16'h0001, 1'b1);
    check(intrOut == 0, "R10 dropped", intrOut, 0);
    waitIntr(0, 0, n, inj);
    check(n == expRise(2), "R10 new holdoff", n, expRise(2));
    wr(CTL_A, 16'h0001); check(intrOut == 0, "R10 clear", intrOut, 0);

    // random trials: R2 R5 R6
    for (int t = 0; t < 60; t++) begin
      int d;
      bit pend;
      d = int'($urandom % 6);
      wr(DLY_A, 16'(d));
      pulse();
      waitIntr(0, 25, n, inj);
      check(n == expRise(d), "R6 coalesced rise", n, expRise(d));
      pend = inj;
      if ($urandom % 2 == 1) begin
        pulse(); pend = 1;
        check(intrOut == 1, "R5 masked", intrOut, 1);
      end
      for (int g = 0; g < 4; g++) begin
        wr(CTL_A, 16'h0001);
        if (pend) begin
          waitIntr(0, 0, n, inj);
          check(n == expRise(d), "R5 pending holdoff", n, expRise(d));
          pend = 0;
        end else begin
          check(intrOut == 0, "R4 final drop", intrOut, 0);
          break;
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule